// File: doc/BRIEF.md
# Dual PLL Configuration Register with Write Lock

This block holds the configuration of two clock multipliers: a main PLL and a dedicated audio PLL. Both draw on one shared reference: a source select (internal or external oscillator) and an input divider. The main PLL has a multiplier and two output dividers of its own. The audio PLL has its own multiplier and output divider. Each PLL has its own enable bit. Software programs the fields over a simple single-cycle register bus and then sets the enables. The configuration and enable outputs drive the analog PLLs directly.

While a PLL runs, the fields it depends on are frozen. A write that targets a frozen field leaves it unchanged and raises a sticky error flag. Hardware turns both PLLs off when the chip enters a low-power mode. It does the same when the external oscillator fails while that oscillator clocks the system, either directly or through a PLL fed from it. The cleared enables read back, so software can see that the PLLs are off.

Top module: `pll_cfg_regs`

## Requirements
- R1: After reset the outputs hold M=16, source internal (0), main N=192, main P code 0, main Q=4, audio N=192, audio R=2. Both enables are 0 and the lock error flag is 0.
- R2: Register layout, with accesses at `regAddr`. Address 0 holds the controls: bit 0 main enable, bit 1 audio enable, bit 8 lock error. Address 1 holds the main settings: M in [5:0], source in bit 6 (1 = external), N in [16:8], P code in [19:18] (divide = 2*(code+1)), Q in [27:24]. Address 2 holds the audio settings: N in [16:8], R in [30:28]. Address 3 reads 0. A write to an unlocked field shows on the outputs and on `regRdData` on the cycle after the write edge.
- R3: While the main enable is 1, writes leave main N, P and Q unchanged.
- R4: While either enable is 1, writes leave M and source unchanged.
- R5: While the audio enable is 1, writes leave audio N and R unchanged. When only the audio PLL is enabled, main N, P and Q at address 1 still accept writes.
- R6: A cycle with `lowPowerEntry` high clears both enables at that edge. This takes priority over a software write to address 0 in the same cycle.
- R7: A cycle with `oscFail` high clears both enables in two cases: when `sysClkSrc` is 1 (external oscillator), or when it is 2 (PLL) and the source bit is 1. With `sysClkSrc` 0, or 2 with an internal source, the enables are left as they are.
- R8: A write to address 1 while either enable is 1, or to address 2 while the audio enable is 1, sets the lock error bit. Writing address 0 with bit 8 = 1 clears it. Writing bit 8 = 0 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Write strobe, one cycle per write |
| regAddr | input | 2 | Register address for write and read |
| regWrData | input | 32 | Write data |
| regRdData | output | 32 | Combinational read data at regAddr |
| lowPowerEntry | input | 1 | Low-power mode entry event |
| oscFail | input | 1 | External oscillator failure event |
| sysClkSrc | input | 2 | Current system clock: 0 internal, 1 external, 2 PLL |
| pllSrcExt | output | 1 | Shared source select, 1 = external |
| pllM | output | 6 | Shared input divider |
| mainPllOn | output | 1 | Main PLL enable |
| mainN | output | 9 | Main multiplier |
| mainPCode | output | 2 | Main system-output divider code |
| mainQ | output | 4 | Main secondary-output divider |
| audioPllOn | output | 1 | Audio PLL enable |
| audioN | output | 9 | Audio multiplier |
| audioR | output | 3 | Audio output divider |

## Verification
Every register write and every forced disable lands at the clock edge that samples it. Its result is due on the outputs and on the read port one cycle after the stimulus is driven. The bench drives each stimulus on a falling edge and checks it on the next falling edge, half a cycle after the capturing edge. It sweeps every combination of enables against writes to every register. It also sweeps every combination of low-power, oscillator-failure, system-clock source and PLL source. For each case it works out the expected field values from the lock and force rules.

// File: rtl/pll_cfg_pkg.sv
package pll_cfg_pkg;

  localparam logic [1:0] ADDR_CTRL  = 2'd0;
  localparam logic [1:0] ADDR_MAIN  = 2'd1;
  localparam logic [1:0] ADDR_AUDIO = 2'd2;

  localparam int CTRL_MAIN_BIT  = 0;
  localparam int CTRL_AUDIO_BIT = 1;
  localparam int CTRL_ERR_BIT   = 8;
  localparam int N_LSB          = 8;
  localparam int P_LSB          = 18;
  localparam int Q_LSB          = 24;
  localparam int R_LSB          = 28;

  typedef enum logic [1:0] {
    CLK_INT = 2'd0,
    CLK_EXT = 2'd1,
    CLK_PLL = 2'd2
  } sysclk_e;

  typedef struct packed {
    logic loadShared;
    logic loadMain;
    logic loadAudio;
    logic loadEnables;
    logic forceOff;
    logic setErr;
    logic clrErr;
  } strobe_t;

endpackage

// File: rtl/pll_cfg_ctrl.sv
module pll_cfg_ctrl
  import pll_cfg_pkg::*;
(
  input  logic       regWrEn,
  input  logic [1:0] regAddr,
  input  logic       errClrBit,
  input  logic       mainOn,
  input  logic       audioOn,
  input  logic       srcExt,
  input  logic       lowPowerEntry,
  input  logic       oscFail,
  input  logic [1:0] sysClkSrc,
  output strobe_t    stb
);

  logic wrCtrl, wrMain, wrAudio;
  logic extDrivesSys;
  logic anyOn;

  always_comb begin
    wrCtrl  = regWrEn && (regAddr == ADDR_CTRL);
    wrMain  = regWrEn && (regAddr == ADDR_MAIN);
    wrAudio = regWrEn && (regAddr == ADDR_AUDIO);
    anyOn   = mainOn || audioOn;

    extDrivesSys = (sysClkSrc == CLK_EXT) || ((sysClkSrc == CLK_PLL) && srcExt);

    stb.forceOff    = lowPowerEntry || (oscFail && extDrivesSys);
    stb.loadEnables = wrCtrl && !stb.forceOff;
    stb.loadShared  = wrMain && !anyOn;
    stb.loadMain    = wrMain && !mainOn;
    stb.loadAudio   = wrAudio && !audioOn;
    stb.setErr      = (wrMain && anyOn) || (wrAudio && audioOn);
    stb.clrErr      = wrCtrl && errClrBit;
  end

endmodule

// File: rtl/pll_cfg_dp.sv
module pll_cfg_dp
  import pll_cfg_pkg::*;
#(
  parameter int M_W     = 6,
  parameter int N_W     = 9,
  parameter int P_W     = 2,
  parameter int Q_W     = 4,
  parameter int R_W     = 3,
  parameter int M_RST   = 16,
  parameter int N_RST   = 192,
  parameter int Q_RST   = 4,
  parameter int AN_RST  = 192,
  parameter int R_RST   = 2
) (
  input  logic           clk,
  input  logic           rstN,
  input  strobe_t        stb,
  input  logic [31:0]    wrData,
  output logic           srcExt,
  output logic [M_W-1:0] pllM,
  output logic           mainOn,
  output logic [N_W-1:0] mainN,
  output logic [P_W-1:0] mainP,
  output logic [Q_W-1:0] mainQ,
  output logic           audioOn,
  output logic [N_W-1:0] audioN,
  output logic [R_W-1:0] audioR,
  output logic           lockErr
);

  localparam int SRC_BIT = M_W;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcExt <= 1'b0;
      pllM   <= M_W'(M_RST);
    end else if (stb.loadShared) begin
      srcExt <= wrData[SRC_BIT];
      pllM   <= wrData[M_W-1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mainN <= N_W'(N_RST);
      mainP <= '0;
      mainQ <= Q_W'(Q_RST);
    end else if (stb.loadMain) begin
      mainN <= wrData[N_LSB +: N_W];
      mainP <= wrData[P_LSB +: P_W];
      mainQ <= wrData[Q_LSB +: Q_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      audioN <= N_W'(AN_RST);
      audioR <= R_W'(R_RST);
    end else if (stb.loadAudio) begin
      audioN <= wrData[N_LSB +: N_W];
      audioR <= wrData[R_LSB +: R_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mainOn  <= 1'b0;
      audioOn <= 1'b0;
    end else if (stb.forceOff) begin
      mainOn  <= 1'b0;
      audioOn <= 1'b0;
    end else if (stb.loadEnables) begin
      mainOn  <= wrData[CTRL_MAIN_BIT];
      audioOn <= wrData[CTRL_AUDIO_BIT];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)           lockErr <= 1'b0;
    else if (stb.setErr) lockErr <= 1'b1;
    else if (stb.clrErr) lockErr <= 1'b0;
  end

  assert_main_locked_R3: assert property (@(posedge clk) disable iff (!rstN)
    $past(mainOn) |-> ($stable(mainN) && $stable(mainP) && $stable(mainQ)));

  assert_shared_locked_R4: assert property (@(posedge clk) disable iff (!rstN)
    $past(mainOn || audioOn) |-> ($stable(pllM) && $stable(srcExt)));

  assert_audio_locked_R5: assert property (@(posedge clk) disable iff (!rstN)
    $past(audioOn) |-> ($stable(audioN) && $stable(audioR)));

  assert_force_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    stb.forceOff |=> (!mainOn && !audioOn));

  assert_err_set_R8: assert property (@(posedge clk) disable iff (!rstN)
    stb.setErr |=> lockErr);

endmodule

// File: rtl/pll_cfg_regs.sv
module pll_cfg_regs
  import pll_cfg_pkg::*;
#(
  parameter int M_W = 6,
  parameter int N_W = 9,
  parameter int Q_W = 4,
  parameter int R_W = 3
) (
  input  logic           clk,
  input  logic           rstN,
  input  logic           regWrEn,
  input  logic [1:0]     regAddr,
  input  logic [31:0]    regWrData,
  output logic [31:0]    regRdData,
  input  logic           lowPowerEntry,
  input  logic           oscFail,
  input  logic [1:0]     sysClkSrc,
  output logic           pllSrcExt,
  output logic [M_W-1:0] pllM,
  output logic           mainPllOn,
  output logic [N_W-1:0] mainN,
  output logic [1:0]     mainPCode,
  output logic [Q_W-1:0] mainQ,
  output logic           audioPllOn,
  output logic [N_W-1:0] audioN,
  output logic [R_W-1:0] audioR
);

  strobe_t stb;
  logic    lockErr;

  pll_cfg_ctrl u_ctrl (
    .regWrEn       (regWrEn),
    .regAddr       (regAddr),
    .errClrBit     (regWrData[CTRL_ERR_BIT]),
    .mainOn        (mainPllOn),
    .audioOn       (audioPllOn),
    .srcExt        (pllSrcExt),
    .lowPowerEntry (lowPowerEntry),
    .oscFail       (oscFail),
    .sysClkSrc     (sysClkSrc),
    .stb           (stb)
  );

  pll_cfg_dp #(
    .M_W (M_W), .N_W (N_W), .P_W (2), .Q_W (Q_W), .R_W (R_W)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .stb     (stb),
    .wrData  (regWrData),
    .srcExt  (pllSrcExt),
    .pllM    (pllM),
    .mainOn  (mainPllOn),
    .mainN   (mainN),
    .mainP   (mainPCode),
    .mainQ   (mainQ),
    .audioOn (audioPllOn),
    .audioN  (audioN),
    .audioR  (audioR),
    .lockErr (lockErr)
  );

  always_comb begin
    regRdData = '0;
    case (regAddr)
      ADDR_CTRL: begin
        regRdData[CTRL_MAIN_BIT]  = mainPllOn;
        regRdData[CTRL_AUDIO_BIT] = audioPllOn;
        regRdData[CTRL_ERR_BIT]   = lockErr;
      end
      ADDR_MAIN: begin
        regRdData[M_W-1:0]      = pllM;
        regRdData[M_W]          = pllSrcExt;
        regRdData[N_LSB +: N_W] = mainN;
        regRdData[P_LSB +: 2]   = mainPCode;
        regRdData[Q_LSB +: Q_W] = mainQ;
      end
      ADDR_AUDIO: begin
        regRdData[N_LSB +: N_W] = audioN;
        regRdData[R_LSB +: R_W] = audioR;
      end
      default: regRdData = '0;
    endcase
  end

  assert_lowpower_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    lowPowerEntry |=> (!mainPllOn && !audioPllOn));

  assert_osc_fail_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    (oscFail && sysClkSrc == CLK_EXT) |=> (!mainPllOn && !audioPllOn));

  assert_int_clk_keeps_R7: assert property (@(posedge clk) disable iff (!rstN)
    (oscFail && !lowPowerEntry && sysClkSrc == CLK_INT && !regWrEn)
      |=> ($stable(mainPllOn) && $stable(audioPllOn)));

endmodule

// File: tb/tb_pll_cfg_regs.sv
module tb_pll_cfg_regs;

  logic        clk = 1'b0;
  logic        rstN;
  logic        regWrEn;
  logic [1:0]  regAddr;
  logic [31:0] regWrData;
  logic [31:0] regRdData;
  logic        lowPowerEntry, oscFail;
  logic [1:0]  sysClkSrc;
  logic        pllSrcExt, mainPllOn, audioPllOn;
  logic [5:0]  pllM;
  logic [8:0]  mainN, audioN;
  logic [1:0]  mainPCode;
  logic [3:0]  mainQ;
  logic [2:0]  audioR;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  pll_cfg_regs dut (
    .clk (clk), .rstN (rstN), .regWrEn (regWrEn), .regAddr (regAddr),
    .regWrData (regWrData), .regRdData (regRdData),
    .lowPowerEntry (lowPowerEntry), .oscFail (oscFail), .sysClkSrc (sysClkSrc),
    .pllSrcExt (pllSrcExt), .pllM (pllM), .mainPllOn (mainPllOn),
    .mainN (mainN), .mainPCode (mainPCode), .mainQ (mainQ),
    .audioPllOn (audioPllOn), .audioN (audioN), .audioR (audioR)
  );

  function automatic logic [31:0] mainWord(int m, int s, int n, int p, int q);
    return (32'(m) & 32'h3f) | (32'(s & 1) << 6) | ((32'(n) & 32'h1ff) << 8)
         | ((32'(p) & 32'h3) << 18) | ((32'(q) & 32'hf) << 24);
  endfunction

  function automatic logic [31:0] audioWord(int n, int r);
    return ((32'(n) & 32'h1ff) << 8) | ((32'(r) & 32'h7) << 28);
  endfunction

  task automatic check(string req, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [1:0] a, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0;
  endtask

  task automatic rd(logic [1:0] a, output logic [31:0] d);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic finishRun();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  endtask

  initial begin
    #(200000 * 10);
    errors++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [31:0] r;
    rstN = 1'b0; regWrEn = 1'b0; regAddr = '0; regWrData = '0;
    lowPowerEntry = 1'b0; oscFail = 1'b0; sysClkSrc = 2'd0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state
    check("R1", "M", 32'(pllM), 32'd16);
    check("R1", "src", 32'(pllSrcExt), 32'd0);
    check("R1", "mainN", 32'(mainN), 32'd192);
    check("R1", "mainP", 32'(mainPCode), 32'd0);
    check("R1", "mainQ", 32'(mainQ), 32'd4);
    check("R1", "audioN", 32'(audioN), 32'd192);
    check("R1", "audioR", 32'(audioR), 32'd2);
    check("R1", "enables", {30'd0, audioPllOn, mainPllOn}, 32'd0);
    rd(2'd0, r);
    check("R1", "ctrl readback", r, 32'd0);

    // R2 sweep of unlocked writes and readback
    for (int i = 0; i < 16; i++) begin
      int m = (i * 7 + 3) % 64;
      int n = (i * 37 + 5) % 512;
      int p = i % 4;
      int q = (i * 3) % 16;
      int s = i % 2;
      int r2 = (i * 5) % 8;
      wr(2'd1, mainWord(m, s, n, p, q));
      wr(2'd2, audioWord((n + 100) % 512, r2));
      check("R2", "M", 32'(pllM), 32'(m));
      check("R2", "src", 32'(pllSrcExt), 32'(s));
      check("R2", "mainN", 32'(mainN), 32'(n));
      check("R2", "mainP", 32'(mainPCode), 32'(p));
      check("R2", "mainQ", 32'(mainQ), 32'(q));
      check("R2", "audioN", 32'(audioN), 32'((n + 100) % 512));
      check("R2", "audioR", 32'(audioR), 32'(r2));
      rd(2'd1, r);
      check("R2", "main readback", r, mainWord(m, s, n, p, q));
      rd(2'd2, r);
      check("R2", "audio readback", r, audioWord((n + 100) % 512, r2));
    end
    rd(2'd3, r);
    check("R2", "addr3 zero", r, 32'd0);

    // R3 R4 R5 R8 lock sweep over enable combinations
    for (int c = 0; c < 4; c++) begin
      logic mOn, aOn;
      mOn = c[0]; aOn = c[1];
      wr(2'd0, 32'h100);
      wr(2'd1, mainWord(10, 0, 100, 1, 5));
      wr(2'd2, audioWord(150, 3));
      wr(2'd0, 32'(c));
      wr(2'd1, mainWord(33, 1, 300, 3, 9));
      wr(2'd2, audioWord(77, 6));
      check("R4", "M locked", 32'(pllM), (mOn || aOn) ? 32'd10 : 32'd33);
      check("R4", "src locked", 32'(pllSrcExt), (mOn || aOn) ? 32'd0 : 32'd1);
      check("R3", "mainN locked", 32'(mainN), mOn ? 32'd100 : 32'd300);
      check("R3", "mainP locked", 32'(mainPCode), mOn ? 32'd1 : 32'd3);
      check("R3", "mainQ locked", 32'(mainQ), mOn ? 32'd5 : 32'd9);
      check("R5", "audioN locked", 32'(audioN), aOn ? 32'd150 : 32'd77);
      check("R5", "audioR locked", 32'(audioR), aOn ? 32'd3 : 32'd6);
      rd(2'd0, r);
      check("R8", "ctrl after locked writes", r,
            {23'd0, (mOn || aOn), 6'd0, aOn, mOn});
      wr(2'd0, 32'(c));
      rd(2'd0, r);
      check("R8", "err kept on bit8=0", r, {23'd0, (mOn || aOn), 6'd0, aOn, mOn});
      wr(2'd0, 32'h100 | 32'(c));
      rd(2'd0, r);
      check("R8", "err cleared", r, {30'd0, aOn, mOn});
    end

    // R6 R7 forced disable sweep
    for (int lp = 0; lp < 2; lp++)
      for (int f = 0; f < 2; f++)
        for (int sc = 0; sc < 3; sc++)
          for (int se = 0; se < 2; se++) begin
            logic expOn;
            wr(2'd0, 32'h100);
            wr(2'd1, mainWord(8, se, 50, 0, 2));
            wr(2'd0, 32'd3);
            @(negedge clk);
            lowPowerEntry = lp[0]; oscFail = f[0]; sysClkSrc = 2'(sc);
            @(negedge clk);
            lowPowerEntry = 1'b0; oscFail = 1'b0; sysClkSrc = 2'd0;
            expOn = !((lp != 0) || ((f != 0) && (sc == 1 || (sc == 2 && se != 0))));
            check(lp != 0 ? "R6" : "R7", "forced enables",
                  {30'd0, audioPllOn, mainPllOn}, {30'd0, expOn, expOn});
            rd(2'd0, r);
            check(lp != 0 ? "R6" : "R7", "ctrl readback", r & 32'h3, {30'd0, expOn, expOn});
          end

    // R6 priority over a same-cycle enable write
    wr(2'd0, 32'h100);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = 2'd0; regWrData = 32'd3; lowPowerEntry = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0; regWrData = '0; lowPowerEntry = 1'b0;
    check("R6", "priority over write", {30'd0, audioPllOn, mainPllOn}, 32'd0);

    finishRun();
  end

endmodule